// File: doc/BRIEF.md
# Shift and rotate execution unit

A single-cycle shift unit for a 32-bit integer pipeline. Each request carries a six-bit function code, a five-bit immediate shift amount, a five-bit rotate-select field and two operands: the value to be shifted and a second operand whose low five bits supply the amount for the variable-amount forms. The unit performs logical left, logical right, arithmetic right and rotate right shifts, each in a fixed-amount and a variable-amount form. It flags function codes that are not shifts as illegal.

The result and the illegal flag are registered once. Requests enter on a valid/ready pair and results leave on a valid/ready pair. A request is accepted on a clock edge where `in_valid` and `in_ready` are both high. Its result is presented with `out_valid` from that edge on. While `out_valid` is high and `out_ready` is low, the output holds and `in_ready` stays low. `in_ready` equals `!out_valid || out_ready`, so a stream with `out_ready` held high runs at one request per cycle, and each result is valid for exactly one cycle.

Top module: `shift_unit`

## Requirements
- R1: Function code 0x00 shifts `in_opa` left by `in_shamt`, filling with zeros.
- R2: Function code 0x02 with rotate-select 0 shifts `in_opa` right by `in_shamt`, filling with zeros.
- R3: Function code 0x02 with rotate-select 1 returns `(in_opa << (32-n)) | (in_opa >> n)`, where n is `in_shamt`.
- R4: Function code 0x03 shifts `in_opa` right by `in_shamt` and fills the vacated bits with copies of bit 31.
- R5: Function codes 0x04, 0x06 and 0x07 act as 0x00, 0x02 and 0x03, with the same rotate-select rule for 0x06. Their amount is `in_opb[4:0]`. Both `in_shamt` and `in_opb[31:5]` have no effect for these codes.
- R6: A rotate by an amount of 0, fixed or variable, returns `in_opa` unchanged.
- R7: Function codes 0x01, 0x05 and 0x08 to 0x3F are illegal. Codes 0x02 and 0x06 with a rotate-select value other than 0 or 1 are also illegal. An illegal request gives `out_illegal` = 1 and `out_result` = 0. For every legal request `out_illegal` = 0, and for codes 0x00, 0x03, 0x04 and 0x07 the rotate-select value has no effect.
- R8: The all-zero request (code 0x00, amount 0, operand 0) is the no-operation encoding. It yields result 0 with `out_illegal` = 0.
- R9: A request accepted at a clock edge appears on `out_result` and `out_illegal` with `out_valid` = 1 right after that edge. When `out_ready` is high and no new request is accepted, `out_valid` drops after one cycle.
- R10: While `out_valid` = 1 and `out_ready` = 0, `in_ready` is 0, `out_result` and `out_illegal` hold their values, and a request offered on the input is not taken.
- R11: Synchronous reset clears `out_valid`, which leaves `in_ready` at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request present |
| in_ready | output | 1 | Unit can take a request |
| in_func | input | 6 | Function code |
| in_shamt | input | 5 | Immediate shift amount |
| in_rotsel | input | 5 | Rotate-select field for codes 0x02 and 0x06 |
| in_opa | input | 32 | Value to shift |
| in_opb | input | 32 | Operand whose low five bits give the variable amount |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Shifted or rotated value |
| out_illegal | output | 1 | Function code or rotate-select is not a shift |

## Verification
Every result is due one register stage after its request is accepted. The bench drives each request on a falling edge and drops it on the next falling edge. It then reads `out_valid`, `out_result` and `out_illegal` at that second falling edge, so the capturing rising edge falls exactly halfway between. At the following falling edge the bench checks that `out_valid` has dropped. For back-pressure, the bench holds `out_ready` low across several falling edges and checks that the held result and a low `in_ready` persist. It then checks that the waiting request comes out one cycle after `out_ready` returns high.

// File: rtl/shift_pkg.sv
package shift_pkg;

  localparam int FN_W = 6;

  localparam logic [FN_W-1:0] FN_SLL  = 6'h00;
  localparam logic [FN_W-1:0] FN_SRL  = 6'h02;
  localparam logic [FN_W-1:0] FN_SRA  = 6'h03;
  localparam logic [FN_W-1:0] FN_SLLV = 6'h04;
  localparam logic [FN_W-1:0] FN_SRLV = 6'h06;
  localparam logic [FN_W-1:0] FN_SRAV = 6'h07;

  typedef enum logic [2:0] {
    SOP_SLL,
    SOP_SRL,
    SOP_SRA,
    SOP_ROTR,
    SOP_BAD
  } shop_e;

endpackage

// File: rtl/shift_decode.sv
module shift_decode
  import shift_pkg::*;
#(
  parameter int SEL_W = 5
) (
  input  logic [FN_W-1:0]  func,
  input  logic [SEL_W-1:0] rotsel,
  output shop_e            op,
  output logic             use_var,
  output logic             illegal
);

  // Right logical or rotate, picked by the select field; other values are illegal.
  function automatic shop_e right_kind(input logic [SEL_W-1:0] sel);
    if (sel == '0) return SOP_SRL;
    else if (sel == SEL_W'(1)) return SOP_ROTR;
    else return SOP_BAD;
  endfunction

  always_comb begin
    op      = SOP_BAD;
    use_var = 1'b0;
    case (func)
      FN_SLL:  op = SOP_SLL;
      FN_SRL:  op = right_kind(rotsel);
      FN_SRA:  op = SOP_SRA;
      FN_SLLV: begin op = SOP_SLL;            use_var = 1'b1; end
      FN_SRLV: begin op = right_kind(rotsel); use_var = 1'b1; end
      FN_SRAV: begin op = SOP_SRA;            use_var = 1'b1; end
      default: op = SOP_BAD;
    endcase
    illegal = (op == SOP_BAD);
  end

endmodule

// File: rtl/shift_core.sv
module shift_core
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = $clog2(DATA_W)
) (
  input  shop_e             op,
  input  logic [AMT_W-1:0]  amt,
  input  logic [DATA_W-1:0] value,
  output logic [DATA_W-1:0] result
);

  logic [DATA_W-1:0] rev_in;
  logic [DATA_W-1:0] rev_out;
  logic [DATA_W-1:0] stage [AMT_W+1];
  logic              sign_fill;
  logic              is_rot;

  // Left shifts run through the right shifter on a bit-reversed word.
  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_in[i] = value[DATA_W-1-i];
  end

  assign stage[0]  = (op == SOP_SLL) ? rev_in : value;
  assign sign_fill = (op == SOP_SRA) & value[DATA_W-1];
  assign is_rot    = (op == SOP_ROTR);

  // One stage per amount bit; a rotate wraps the bits shifted out, so zero amount passes through.
  for (genvar k = 0; k < AMT_W; k++) begin : g_stage
    localparam int SH = 1 << k;
    logic [SH-1:0] fill;
    assign fill = is_rot ? stage[k][SH-1:0] : {SH{sign_fill}};
    assign stage[k+1] = amt[k] ? {fill, stage[k][DATA_W-1:SH]} : stage[k];
  end

  always_comb begin
    for (int i = 0; i < DATA_W; i++) rev_out[i] = stage[AMT_W][DATA_W-1-i];
  end

  always_comb begin
    case (op)
      SOP_SLL: result = rev_out;
      SOP_BAD: result = '0;
      default: result = stage[AMT_W];
    endcase
  end

endmodule

// File: rtl/shift_outreg.sv
module shift_outreg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] d_result,
  input  logic              d_illegal,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  assign in_ready = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_result  <= '0;
      out_illegal <= 1'b0;
    end else if (in_ready) begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_result  <= d_result;
        out_illegal <= d_illegal;
      end
    end
  end

  // R9: an accepted request is presented on the next cycle
  a_r9_accept_to_valid: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> out_valid);

  // R9: with the result taken and nothing new accepted, valid drops
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready && !in_valid) |=> !out_valid);

  // R10: a stalled result holds
  a_r10_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_illegal)));

  // R11: reset clears valid
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> !out_valid);

endmodule

// File: rtl/shift_unit.sv
module shift_unit
  import shift_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int SEL_W  = 5,
  localparam int AMT_W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [FN_W-1:0]   in_func,
  input  logic [AMT_W-1:0]  in_shamt,
  input  logic [SEL_W-1:0]  in_rotsel,
  input  logic [DATA_W-1:0] in_opa,
  input  logic [DATA_W-1:0] in_opb,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic              out_illegal
);

  shop_e             dec_op;
  logic              dec_var;
  logic              dec_illegal;
  logic [AMT_W-1:0]  amt;
  logic [DATA_W-1:0] core_result;
  logic              unused_opb_hi;

  assign unused_opb_hi = ^in_opb[DATA_W-1:AMT_W];

  shift_decode #(.SEL_W(SEL_W)) decode_i (
    .func    (in_func),
    .rotsel  (in_rotsel),
    .op      (dec_op),
    .use_var (dec_var),
    .illegal (dec_illegal)
  );

  assign amt = dec_var ? in_opb[AMT_W-1:0] : in_shamt;

  shift_core #(.DATA_W(DATA_W), .AMT_W(AMT_W)) core_i (
    .op     (dec_op),
    .amt    (amt),
    .value  (in_opa),
    .result (core_result)
  );

  shift_outreg #(.DATA_W(DATA_W)) outreg_i (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .d_result    (core_result),
    .d_illegal   (dec_illegal),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_illegal (out_illegal)
  );

  // R6: a zero-amount rotate passes the operand through the core
  a_r6_rot_zero: assert property (@(posedge clk) disable iff (rst)
    (in_valid && dec_op == SOP_ROTR && amt == '0) |-> (core_result == in_opa));

  // R7: an illegal request registers a zero result
  a_r7_illegal_zero: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_result == '0));

endmodule

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [5:0]  in_func = '0;
  logic [4:0]  in_shamt = '0;
  logic [4:0]  in_rotsel = '0;
  logic [31:0] in_opa = '0;
  logic [31:0] in_opb = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic        out_illegal;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_unit dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_func(in_func), .in_shamt(in_shamt), .in_rotsel(in_rotsel),
    .in_opa(in_opa), .in_opb(in_opb), .out_valid(out_valid),
    .out_ready(out_ready), .out_result(out_result), .out_illegal(out_illegal)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic [5:0]  f;
    logic [4:0]  sh;
    logic [4:0]  rs;
    logic [31:0] a;
    logic [31:0] b;
  } vec_t;

  localparam int NV = 22;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 6'h00, 5'd4,  5'd0,  32'h8000_00F1, 32'h0},          // R1
    '{4'd1, 6'h00, 5'd31, 5'd0,  32'h0000_0001, 32'hFFFF_FFFF},  // R1
    '{4'd2, 6'h02, 5'd8,  5'd0,  32'hF000_0000, 32'h0},          // R2
    '{4'd3, 6'h02, 5'd4,  5'd1,  32'h1234_5678, 32'h0},          // R3
    '{4'd3, 6'h02, 5'd31, 5'd1,  32'h8000_0001, 32'h0},          // R3
    '{4'd4, 6'h03, 5'd4,  5'd0,  32'h8000_0000, 32'h0},          // R4
    '{4'd4, 6'h03, 5'd31, 5'd0,  32'h4000_0000, 32'h0},          // R4
    '{4'd4, 6'h03, 5'd31, 5'd0,  32'h8000_0000, 32'h0},          // R4
    '{4'd5, 6'h04, 5'd17, 5'd0,  32'h0000_0001, 32'hFFFF_FFE3},  // R5
    '{4'd5, 6'h06, 5'd3,  5'd0,  32'h0000_00F0, 32'h0000_0044},  // R5
    '{4'd5, 6'h06, 5'd0,  5'd1,  32'h0000_00AB, 32'h0000_0028},  // R5
    '{4'd5, 6'h07, 5'd2,  5'd0,  32'h8000_0000, 32'h0000_001F},  // R5
    '{4'd6, 6'h02, 5'd0,  5'd1,  32'hDEAD_BEEF, 32'h0},          // R6
    '{4'd6, 6'h06, 5'd9,  5'd1,  32'hCAFE_F00D, 32'h0000_0020},  // R6
    '{4'd7, 6'h01, 5'd4,  5'd0,  32'hFFFF_FFFF, 32'h1},          // R7
    '{4'd7, 6'h05, 5'd4,  5'd0,  32'hFFFF_FFFF, 32'h1},          // R7
    '{4'd7, 6'h08, 5'd1,  5'd0,  32'h1234_5678, 32'h1},          // R7
    '{4'd7, 6'h3F, 5'd1,  5'd0,  32'h1234_5678, 32'h1},          // R7
    '{4'd7, 6'h02, 5'd1,  5'd2,  32'h1234_5678, 32'h0},          // R7
    '{4'd7, 6'h06, 5'd1,  5'd31, 32'h1234_5678, 32'h3},          // R7
    '{4'd7, 6'h03, 5'd4,  5'd9,  32'hF000_0000, 32'h0},          // R7 rotsel ignored
    '{4'd8, 6'h00, 5'd0,  5'd0,  32'h0,         32'h0}           // R8
  };

  // Model written from the requirements.
  function automatic logic [32:0] model(input vec_t v);
    logic [4:0] n;
    logic [31:0] r;
    logic bad;
    bad = 1'b0;
    r = '0;
    n = (v.f == 6'h04 || v.f == 6'h06 || v.f == 6'h07) ? v.b[4:0] : v.sh;
    case (v.f)
      6'h00, 6'h04: r = v.a << n;
      6'h03, 6'h07: r = 32'($signed(v.a) >>> n);
      6'h02, 6'h06: begin
        if (v.rs == 5'd0) r = v.a >> n;
        else if (v.rs == 5'd1) r = (n == 0) ? v.a : ((v.a << (32 - n)) | (v.a >> n));
        else bad = 1'b1;
      end
      default: bad = 1'b1;
    endcase
    if (bad) r = '0;
    return {bad, r};
  endfunction

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_func = v.f; in_shamt = v.sh; in_rotsel = v.rs; in_opa = v.a; in_opb = v.b;
  endtask

  task automatic send_and_check(input vec_t v);
    logic [32:0] e;
    string tag;
    e = model(v);
    tag = $sformatf("R%0d", v.req);
    @(negedge clk);
    drive(v);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R9", "out_valid after accept", 32'(out_valid), 32'd1);
    check(tag, "result", out_result, e[31:0]);
    check(tag, "illegal", 32'(out_illegal), 32'(e[32]));
  endtask

  function automatic vec_t mk(input logic [5:0] f, input logic [4:0] sh, input logic [4:0] rs,
                              input logic [31:0] a, input logic [31:0] b);
    vec_t v;
    v.req = 4'd0; v.f = f; v.sh = sh; v.rs = rs; v.a = a; v.b = b;
    return v;
  endfunction

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL R9 watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    vec_t va;
    vec_t vb;
    repeat (3) @(negedge clk);
    // R11: reset state
    check("R11", "out_valid in reset", 32'(out_valid), 32'd0);
    check("R11", "in_ready in reset", 32'(in_ready), 32'd1);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) send_and_check(VECS[i]);

    // R9: valid lasts a single cycle when the consumer is ready
    send_and_check(mk(6'h00, 5'd1, 5'd0, 32'h3, 32'h0));
    @(negedge clk);
    check("R9", "out_valid drops", 32'(out_valid), 32'd0);

    // R10: back-pressure holds the result and refuses the next request
    va = mk(6'h02, 5'd4, 5'd1, 32'h0000_000F, 32'h0);
    vb = mk(6'h00, 5'd8, 5'd0, 32'h0000_00FF, 32'h0);
    out_ready = 1'b0;
    @(negedge clk);
    drive(va);
    in_valid = 1'b1;
    @(negedge clk);
    drive(vb);
    check("R10", "in_ready while stalled", 32'(in_ready), 32'd0);
    check("R10", "first result", out_result, 32'hF000_0000);
    @(negedge clk);
    @(negedge clk);
    check("R10", "valid held", 32'(out_valid), 32'd1);
    check("R10", "result held", out_result, 32'hF000_0000);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R10", "waiting request after release", out_result, 32'h0000_FF00);
    check("R10", "valid for waiting request", 32'(out_valid), 32'd1);
    @(negedge clk);
    check("R9", "valid drops after release", 32'(out_valid), 32'd0);

    // R11: reset mid-run clears a stalled result
    out_ready = 1'b0;
    drive(vb);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R11", "stalled before reset", 32'(out_valid), 32'd1);
    rst = 1'b1;
    @(negedge clk);
    check("R11", "out_valid cleared", 32'(out_valid), 32'd0);
    check("R11", "in_ready after reset", 32'(in_ready), 32'd1);
    rst = 1'b0;
    out_ready = 1'b1;

    // R8: no-op after reset is legal and zero
    send_and_check(mk(6'h00, 5'd0, 5'd0, 32'h0, 32'h0));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule